// File: doc/BRIEF.md
# Power Manager Operating State Controller

This block is the supervisory sequencer of a power management controller. It holds the device in one of four operating states and drives the regulator enables, the active-low host reset and the register clear and retention controls from that state. It contains an initialization timer that the host must stop after each reset release, a dwell timer for the fault state, a history of soft faults that turns a repeat into a severe fault, and a severe-fault counter that locks the device on the third severe fault.

The states are ACTIVE (code 0), DISABLED (code 1), FAULT (code 2) and LOCKED (code 3). The transitions are named as follows. POR takes any state to ACTIVE on power-on reset. SEVERE takes ACTIVE to FAULT on a severe fault. LOCKOUT takes ACTIVE straight to LOCKED on the third severe fault. REQ_DIS and REQ_LOCK take ACTIVE to FAULT on a host request and record the requested target. DWELL_DONE takes FAULT to its recorded target (ACTIVE, DISABLED or LOCKED) after the dwell. WAKE takes DISABLED or LOCKED to ACTIVE on a valid enable event. A soft reset pulses the host reset and keeps the state unchanged.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While power-on reset is applied, and after it is released, the state is ACTIVE (state_o = 0), every regulator enable bit is 1 and wr_en_o is 1.
- R2: On every entry into ACTIVE, and on every soft reset, host_rst_n_o is driven low for exactly RST_MIN cycles. It is held low in FAULT, LOCKED and DISABLED.
- R3: The initialization timer starts when host_rst_n_o is released. It stops, and never expires, once one spi_ok_i strobe and one wd_ok_i strobe have both been seen, in either order.
- R4: The first expiry of the initialization timer, INIT_CYC cycles after release, causes a soft reset and the state stays ACTIVE. The next expiry within the same ACTIVE period is a severe fault and enters FAULT.
- R5: In FAULT all regulator enables and wr_en_o are 0, clr_regs_o is 1 and keep_evt_o is 1. After a severe fault the state stays in FAULT for exactly FAULT_CYC cycles and then returns to ACTIVE.
- R6: A pulse on req_dis_i or req_lock_i in ACTIVE enters FAULT for FAULT_CYC cycles and then enters DISABLED or LOCKED. If both are pulsed together, LOCKED wins.
- R7: The first soft_vld_i with a given soft_code_i causes a soft reset only. A second one with the same code is a severe fault. A pulse on wd_ovf_i always causes a soft reset only, however often it repeats.
- R8: Severe faults are severe_i, a repeated soft code and the second initialization expiry. The third severe fault enters LOCKED directly, with no fault dwell.
- R9: In LOCKED, clr_regs_o and keep_lim_o are 1 and keep_evt_o is 0. In DISABLED, clr_regs_o is 1 and both keep outputs are 0. In both states all regulator enables and wr_en_o are 0.
- R10: DISABLED and LOCKED are left only on a rising edge of en_i after two-flop synchronization. A level held high, severe_i, soft_vld_i and host requests do not change the state.
- R11: Leaving DISABLED or LOCKED through an enable edge clears the severe-fault count and the soft-fault history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| en_i | input | 1 | Asynchronous enable input |
| spi_ok_i | input | 1 | Strobe: valid host serial transfer seen |
| wd_ok_i | input | 1 | Strobe: watchdog serviced correctly |
| wd_ovf_i | input | 1 | Strobe: watchdog error counter overflow |
| soft_vld_i | input | 1 | Strobe: soft fault reported |
| soft_code_i | input | CODE_W | Code of the reported soft fault |
| severe_i | input | 1 | Strobe: severe fault |
| req_dis_i | input | 1 | Host request to enter DISABLED |
| req_lock_i | input | 1 | Host request to enter LOCKED |
| reg_en_o | output | NREG | Regulator and monitor enables, bit 0 = first regulator |
| wr_en_o | output | 1 | Regulator configuration writable |
| host_rst_n_o | output | 1 | Active-low host reset |
| clr_regs_o | output | 1 | Clear the non-retained registers |
| keep_evt_o | output | 1 | Retain all event registers |
| keep_lim_o | output | 1 | Retain only the reduced event set |
| state_o | output | 2 | Current state code |

## Verification
The bench goes after the escalation boundaries. A first init expiry must only pulse the reset, while a second must reach FAULT. A repeated soft code must escalate, a repeated watchdog overflow must not, and the third severe fault must skip the dwell and lock. A design that miscounts any of these would either lock a healthy device or never reach FAULT. It also holds en_i high across entry into DISABLED or LOCKED to catch a level-sensitive wake. After a wake it repeats an old soft code and a new severe fault, which exposes a design that keeps stale history or counts. The dwell length, reset pulse length and init timeout are measured to the cycle, so an off-by-one counter shows up.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE   = 2'd0,
        ST_DISABLED = 2'd1,
        ST_FAULT    = 2'd2,
        ST_LOCKED   = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/pwr_en_sync.sv
// Synchronizes the enable input and flags its rising edge.
module pwr_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sh_q[STAGES-1];
    end

    assign rise_o = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pwr_soft_track.sv
// Remembers which soft-fault codes have occurred since the last wake.
module pwr_soft_track #(
    parameter int NCODE  = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              first_o,
    output logic              rep_o
);
    logic [NCODE-1:0] hist_q;
    logic             hit;

    assign hit     = hist_q[code_i];
    assign first_o = take_i & ~hit;
    assign rep_o   = take_i & hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hist_q <= '0;
        else if (clr_i)  hist_q <= '0;
        else if (take_i) hist_q[code_i] <= 1'b1;
    end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int NREG      = 4,
    parameter int NCODE     = 8,
    parameter int CODE_W    = (NCODE > 1) ? $clog2(NCODE) : 1,
    parameter int RST_MIN   = 100,
    parameter int INIT_CYC  = 1000000,
    parameter int FAULT_CYC = 200000,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              spi_ok_i,
    input  logic              wd_ok_i,
    input  logic              wd_ovf_i,
    input  logic              soft_vld_i,
    input  logic [CODE_W-1:0] soft_code_i,
    input  logic              severe_i,
    input  logic              req_dis_i,
    input  logic              req_lock_i,
    output logic [NREG-1:0]   reg_en_o,
    output logic              wr_en_o,
    output logic              host_rst_n_o,
    output logic              clr_regs_o,
    output logic              keep_evt_o,
    output logic              keep_lim_o,
    output logic [1:0]        state_o
);
    localparam int RST_W   = $clog2(RST_MIN + 1);
    localparam int INIT_W  = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
    localparam int FAULT_W = (FAULT_CYC > 1) ? $clog2(FAULT_CYC) : 1;
    localparam logic [RST_W-1:0]   RST_LOAD   = RST_W'(RST_MIN);
    localparam logic [INIT_W-1:0]  INIT_LAST  = INIT_W'(INIT_CYC - 1);
    localparam logic [FAULT_W-1:0] FAULT_LAST = FAULT_W'(FAULT_CYC - 1);

    pwr_state_e state_q, state_d, tgt_q, tgt_d;

    logic [RST_W-1:0]   rst_cnt_q;
    logic [INIT_W-1:0]  init_cnt_q;
    logic [FAULT_W-1:0] dwell_q;
    logic [1:0]         sev_cnt_q;
    logic init_run_q, init_err_q, spi_seen_q, wd_seen_q;

    logic in_act, idle, en_rise, wake;
    logic soft_first, soft_rep;
    logic done_now, init_exp, sev_evt, soft_rst, enter_act;

    assign in_act = (state_q == ST_ACTIVE);
    assign idle   = (state_q == ST_DISABLED) || (state_q == ST_LOCKED);
    assign wake   = idle && en_rise;

    pwr_en_sync #(.STAGES(SYNC_STG)) u_en_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (en_i),
        .rise_o  (en_rise)
    );

    pwr_soft_track #(.NCODE(NCODE), .CODE_W(CODE_W)) u_soft_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (wake),
        .take_i  (in_act && soft_vld_i),
        .code_i  (soft_code_i),
        .first_o (soft_first),
        .rep_o   (soft_rep)
    );

    // Fault classification
    assign done_now = init_run_q && (spi_seen_q || spi_ok_i) && (wd_seen_q || wd_ok_i);
    assign init_exp = init_run_q && !done_now && (init_cnt_q == INIT_LAST);
    assign sev_evt  = in_act && (severe_i || soft_rep || (init_exp && init_err_q));
    assign soft_rst = in_act && !sev_evt &&
                      (wd_ovf_i || soft_first || (init_exp && !init_err_q));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (sev_evt) begin
                    state_d = (sev_cnt_q == 2'd2) ? ST_LOCKED : ST_FAULT;
                    tgt_d   = ST_ACTIVE;
                end else if (req_lock_i) begin
                    state_d = ST_FAULT;
                    tgt_d   = ST_LOCKED;
                end else if (req_dis_i) begin
                    state_d = ST_FAULT;
                    tgt_d   = ST_DISABLED;
                end
            end
            ST_FAULT: begin
                if (dwell_q == FAULT_LAST) state_d = tgt_q;
            end
            ST_DISABLED, ST_LOCKED: begin
                if (en_rise) state_d = ST_ACTIVE;
            end
        endcase
    end

    assign enter_act = !in_act && (state_d == ST_ACTIVE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            tgt_q   <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // Timers and fault counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_cnt_q  <= RST_LOAD;
            init_cnt_q <= '0;
            dwell_q    <= '0;
            sev_cnt_q  <= '0;
            init_run_q <= 1'b0;
            init_err_q <= 1'b0;
            spi_seen_q <= 1'b0;
            wd_seen_q  <= 1'b0;
        end else begin
            dwell_q <= (state_q == ST_FAULT) ? dwell_q + 1'b1 : '0;

            if (wake)                               sev_cnt_q <= '0;
            else if (sev_evt && sev_cnt_q != 2'd3)  sev_cnt_q <= sev_cnt_q + 2'd1;

            if (enter_act || !in_act) begin
                rst_cnt_q  <= RST_LOAD;
                init_run_q <= 1'b0;
                init_err_q <= 1'b0;
            end else if (soft_rst) begin
                rst_cnt_q  <= RST_LOAD;
                init_run_q <= 1'b0;
                init_err_q <= init_err_q | init_exp;
            end else begin
                if (rst_cnt_q != '0) begin
                    rst_cnt_q <= rst_cnt_q - 1'b1;
                    if (rst_cnt_q == RST_W'(1)) begin
                        init_run_q <= 1'b1;
                        init_cnt_q <= '0;
                        spi_seen_q <= 1'b0;
                        wd_seen_q  <= 1'b0;
                    end
                end
                if (init_run_q) begin
                    if (done_now) begin
                        init_run_q <= 1'b0;
                    end else if (init_exp) begin
                        init_run_q <= 1'b0;
                        init_err_q <= 1'b1;
                    end else begin
                        init_cnt_q <= init_cnt_q + 1'b1;
                        spi_seen_q <= spi_seen_q | spi_ok_i;
                        wd_seen_q  <= wd_seen_q | wd_ok_i;
                    end
                end
            end
        end
    end

    // Outputs
    always_comb begin
        reg_en_o     = '0;
        wr_en_o      = 1'b0;
        host_rst_n_o = 1'b0;
        clr_regs_o   = 1'b1;
        keep_evt_o   = 1'b0;
        keep_lim_o   = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                reg_en_o     = '1;
                wr_en_o      = 1'b1;
                host_rst_n_o = (rst_cnt_q == '0);
                clr_regs_o   = 1'b0;
            end
            ST_FAULT:    keep_evt_o = 1'b1;
            ST_LOCKED:   keep_lim_o = 1'b1;
            ST_DISABLED: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
    import pwr_state_pkg::*;
#(
    parameter int NREG      = 4,
    parameter int FAULT_CYC = 200000
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      state_o,
    input logic [NREG-1:0] reg_en_o,
    input logic            wr_en_o,
    input logic            host_rst_n_o,
    input logic            keep_evt_o,
    input logic            keep_lim_o
);
    localparam int DW = $clog2(FAULT_CYC + 1) + 1;
    localparam logic [DW-1:0] DMAX = '1;

    logic [DW-1:0] dcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       dcnt <= '0;
        else if (state_o == ST_FAULT && dcnt != DMAX)     dcnt <= dcnt + 1'b1;
        else if (state_o != ST_FAULT)                     dcnt <= '0;
    end

    AST_RST_HELD_OUTSIDE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_ACTIVE) |-> !host_rst_n_o); // R2

    AST_RAILS_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en_o != '0) |-> (state_o == ST_ACTIVE && wr_en_o)); // R9

    AST_KEEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({keep_evt_o, keep_lim_o, wr_en_o})); // R9

    AST_FAULT_DWELL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == ST_FAULT && state_o != ST_FAULT) |-> (dcnt == DW'(FAULT_CYC))); // R5

    AST_DIS_VIA_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) != ST_DISABLED && state_o == ST_DISABLED) |-> ($past(state_o) == ST_FAULT)); // R6

    AST_IDLE_EXIT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_o) == ST_DISABLED || $past(state_o) == ST_LOCKED) && state_o != $past(state_o))
        |-> (state_o == ST_ACTIVE)); // R10
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.NREG(NREG), .FAULT_CYC(FAULT_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_o      (state_o),
    .reg_en_o     (reg_en_o),
    .wr_en_o      (wr_en_o),
    .host_rst_n_o (host_rst_n_o),
    .keep_evt_o   (keep_evt_o),
    .keep_lim_o   (keep_lim_o)
);

// File: tb/pwr_state_ctrl_bench.sv
module pwr_state_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 3, NCODE = 4, CW = 2;
    localparam int RST_MIN = 4, INIT_CYC = 20, FAULT_CYC = 10;
    localparam int S_ACT = 0, S_DIS = 1, S_FLT = 2, S_LCK = 3;

    logic clk = 1'b0, rst_n = 1'b0, en_i = 1'b0;
    logic spi_ok_i = 1'b0, wd_ok_i = 1'b0, wd_ovf_i = 1'b0, soft_vld_i = 1'b0;
    logic [CW-1:0] soft_code_i = '0;
    logic severe_i = 1'b0, req_dis_i = 1'b0, req_lock_i = 1'b0;
    logic [NREG-1:0] reg_en_o;
    logic wr_en_o, host_rst_n_o, clr_regs_o, keep_evt_o, keep_lim_o;
    logic [1:0] state_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    pwr_state_ctrl #(.NREG(NREG), .NCODE(NCODE), .CODE_W(CW), .RST_MIN(RST_MIN),
                     .INIT_CYC(INIT_CYC), .FAULT_CYC(FAULT_CYC)) u_pwr_state_ctrl (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .spi_ok_i(spi_ok_i), .wd_ok_i(wd_ok_i),
        .wd_ovf_i(wd_ovf_i), .soft_vld_i(soft_vld_i), .soft_code_i(soft_code_i),
        .severe_i(severe_i), .req_dis_i(req_dis_i), .req_lock_i(req_lock_i),
        .reg_en_o(reg_en_o), .wr_en_o(wr_en_o), .host_rst_n_o(host_rst_n_o),
        .clr_regs_o(clr_regs_o), .keep_evt_o(keep_evt_o), .keep_lim_o(keep_lim_o),
        .state_o(state_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_rel(output int n);
        n = 0;
        while (!host_rst_n_o && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic service();
        int n;
        wait_rel(n);
        spi_ok_i = 1'b1; wd_ok_i = 1'b1;
        @(negedge clk);
        spi_ok_i = 1'b0; wd_ok_i = 1'b0;
    endtask

    task automatic wait_state(input int s);
        int n = 0;
        while (state_o != 2'(s) && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic count_fault(output int n);
        n = 0;
        while (state_o == 2'(S_FLT) && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic pulse_sev();
        severe_i = 1'b1; @(negedge clk); severe_i = 1'b0;
    endtask

    task automatic pulse_soft(input int code);
        soft_code_i = CW'(code); soft_vld_i = 1'b1; @(negedge clk); soft_vld_i = 1'b0;
    endtask

    task automatic pulse_ovf();
        wd_ovf_i = 1'b1; @(negedge clk); wd_ovf_i = 1'b0;
    endtask

    task automatic pulse_req(input bit dis, input bit lck);
        req_dis_i = dis; req_lock_i = lck; @(negedge clk);
        req_dis_i = 1'b0; req_lock_i = 1'b0;
    endtask

    task automatic t_por();
        int n;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 state in reset", state_o, S_ACT);
        chk("R1 rails in reset", reg_en_o, 3'b111);
        chk("R1 wr_en in reset", wr_en_o, 1);
        chk("R2 host reset in reset", host_rst_n_o, 0);
        rst_n = 1'b1;
        wait_rel(n);
        chk("R2 reset pulse length", n, RST_MIN);
        chk("R1 state after release", state_o, S_ACT);
    endtask

    task automatic t_init_ok();
        int n, lows = 0;
        do_reset();
        wait_rel(n);
        repeat (3) @(negedge clk);
        wd_ok_i = 1'b1; @(negedge clk); wd_ok_i = 1'b0;
        repeat (5) @(negedge clk);
        spi_ok_i = 1'b1; @(negedge clk); spi_ok_i = 1'b0;
        for (int i = 0; i < 3 * INIT_CYC; i++) begin
            @(negedge clk);
            if (!host_rst_n_o) lows++;
        end
        chk("R3 no expiry after both seen", lows, 0);
        chk("R3 still active", state_o, S_ACT);
    endtask

    task automatic t_init_exp();
        int n, k = 0;
        do_reset();
        wait_rel(n);
        spi_ok_i = 1'b1;
        while (host_rst_n_o && k < 1000) begin
            @(negedge clk); spi_ok_i = 1'b0; k++;
        end
        chk("R4 first expiry time", k, INIT_CYC);
        chk("R4 first expiry keeps state", state_o, S_ACT);
        wait_rel(n);
        k = 0;
        while (state_o == 2'(S_ACT) && k < 1000) begin @(negedge clk); k++; end
        chk("R4 second expiry time", k, INIT_CYC);
        chk("R4 second expiry to fault", state_o, S_FLT);
        chk("R5 rails off in fault", reg_en_o, 0);
        chk("R5 clear in fault", clr_regs_o, 1);
        chk("R5 keep events in fault", keep_evt_o, 1);
        chk("R5 wr_en off in fault", wr_en_o, 0);
        count_fault(n);
        chk("R5 dwell length", n, FAULT_CYC);
        chk("R5 return to active", state_o, S_ACT);
    endtask

    task automatic t_soft();
        do_reset();
        service();
        pulse_soft(1);
        chk("R7 first code resets host", host_rst_n_o, 0);
        chk("R7 first code keeps state", state_o, S_ACT);
        service();
        pulse_soft(2);
        chk("R7 other code only resets", state_o, S_ACT);
        service();
        pulse_soft(1);
        chk("R7 repeated code is severe", state_o, S_FLT);
        wait_state(S_ACT);
        service();
        pulse_ovf();
        chk("R7 overflow resets host", host_rst_n_o, 0);
        service();
        pulse_ovf();
        chk("R7 repeated overflow exempt", state_o, S_ACT);
        chk("R7 repeated overflow resets", host_rst_n_o, 0);
    endtask

    task automatic t_lock();
        do_reset();
        service();
        pulse_soft(3);
        service();
        pulse_soft(3);
        chk("R8 severe one", state_o, S_FLT);
        wait_state(S_ACT);
        service();
        pulse_sev();
        chk("R8 severe two", state_o, S_FLT);
        wait_state(S_ACT);
        service();
        pulse_sev();
        chk("R8 third severe locks directly", state_o, S_LCK);
        chk("R9 locked keep_lim", keep_lim_o, 1);
        chk("R9 locked keep_evt", keep_evt_o, 0);
        chk("R9 locked clear", clr_regs_o, 1);
        chk("R9 locked rails", reg_en_o, 0);
        chk("R2 reset held in locked", host_rst_n_o, 0);
        pulse_sev(); pulse_soft(0); pulse_req(1'b1, 1'b1);
        repeat (20) @(negedge clk);
        chk("R10 locked ignores faults", state_o, S_LCK);
        en_i = 1'b1;
        wait_state(S_ACT);
        chk("R10 enable edge wakes", state_o, S_ACT);
        service();
        pulse_soft(3);
        chk("R11 soft history cleared", state_o, S_ACT);
        service();
        pulse_sev();
        chk("R11 severe count cleared", state_o, S_FLT);
        wait_state(S_ACT);
    endtask

    task automatic t_req();
        int n;
        do_reset();
        service();
        pulse_req(1'b1, 1'b0);
        chk("R6 disable request enters fault", state_o, S_FLT);
        count_fault(n);
        chk("R6 request dwell length", n, FAULT_CYC);
        chk("R6 disabled reached", state_o, S_DIS);
        chk("R9 disabled rails", reg_en_o, 0);
        chk("R9 disabled clear", clr_regs_o, 1);
        chk("R9 disabled keeps", {keep_evt_o, keep_lim_o, wr_en_o}, 0);
        pulse_sev(); pulse_soft(2);
        repeat (10) @(negedge clk);
        chk("R10 disabled ignores faults", state_o, S_DIS);
        en_i = 1'b1;
        wait_state(S_ACT);
        chk("R10 wake from disabled", state_o, S_ACT);
        service();
        pulse_req(1'b1, 1'b1);
        count_fault(n);
        chk("R6 lock wins over disable", state_o, S_LCK);
        repeat (20) @(negedge clk);
        chk("R10 held enable level no wake", state_o, S_LCK);
        en_i = 1'b0;
        repeat (4) @(negedge clk);
        en_i = 1'b1;
        wait_state(S_ACT);
        chk("R10 new edge wakes locked", state_o, S_ACT);
    endtask

    initial begin
        t_por();
        t_init_ok();
        t_init_exp();
        t_soft();
        t_lock();
        t_req();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule